// File: doc/BRIEF.md
# Processor Operating Mode Decoder

This block turns a handful of architectural control bits into a compact, registered summary of how an x86-style core is currently executing. Its inputs are the long-mode-active flag, the protection-enable and paging bits of the main control register, three code segment attributes (the 64-bit flag, the default-size flag and the descriptor privilege level), the stack segment default-size flag and the virtual-8086 flag. From these it produces the mode, the submode, the current privilege level, the paging and protection flags, and the size codes for operands, addresses and the stack. An instruction decoder reads these outputs.

The unit keeps a snapshot of the source bits. When any of them differs from the snapshot, it recomputes the summary on the next clock and pulses a valid strobe. A separate recompute strobe forces the same reload. The data word that comes with that strobe is thrown away, so it works like a write to the summary register whose only effect is a refresh from the current sources.

Top module: `mode_summary_unit`

## Requirements
- R1: With long-mode-active set, mode_o is 1 (Long). submode_o is 0 (64-bit) when the code segment 64-bit flag is set and 1 (Compatibility) when it is clear.
- R2: With long-mode-active clear, mode_o is 0 (Legacy). submode_o is 4 (Real) when protection-enable is 0, 3 (Virtual-8086) when protection-enable is 1 and the VM flag is 1, and 2 (Protected) when protection-enable is 1 and the VM flag is 0.
- R3: cpl_o equals the code segment privilege level, paging_o equals the paging bit and prot_o equals the protection-enable bit.
- R4: Size codes are 1 = 16-bit, 2 = 32-bit and 3 = 64-bit. In the 64-bit submode, or when the code segment default-size flag is set, op_def_o = 2 and op_alt_o = 1. Otherwise op_def_o = 1 and op_alt_o = 2.
- R5: In the 64-bit submode, addr_def_o = 3 and addr_alt_o = 2. Otherwise, with the code segment default-size flag set, addr_def_o = 2 and addr_alt_o = 1. Otherwise addr_def_o = 1 and addr_alt_o = 2.
- R6: stack_o is 3 in the 64-bit submode. Otherwise it is 2 when the stack segment default-size flag is set and 1 when it is clear.
- R7: A change on any source input appears on the summary outputs one clock later, together with a one-cycle pulse on upd_valid_o. When the sources hold and no recompute strobe is given, upd_valid_o stays 0 and the outputs hold.
- R8: A recompute strobe pulses upd_valid_o one clock later. kick_data_i has no effect on any output.
- R9: While reset is held, the outputs show Legacy/Real mode (mode_o 0, submode_o 4), cpl_o 0, paging_o 0, prot_o 0, operand 1/2, address 1/2, stack 1 and upd_valid_o 0. Reset asserts asynchronously and releases after two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| lma_i | input | 1 | Long mode active |
| pe_i | input | 1 | Protection enable |
| pg_i | input | 1 | Paging enable |
| cs_long_i | input | 1 | Code segment 64-bit flag |
| cs_big_i | input | 1 | Code segment default-size flag |
| cs_dpl_i | input | 2 | Code segment privilege level |
| ss_big_i | input | 1 | Stack segment default-size flag |
| vm_i | input | 1 | Virtual-8086 flag |
| kick_i | input | 1 | Recompute strobe |
| kick_data_i | input | 32 | Data written with the strobe (discarded) |
| mode_o | output | 1 | 0 Legacy, 1 Long |
| submode_o | output | 3 | 0 64-bit, 1 Compat, 2 Protected, 3 V86, 4 Real |
| cpl_o | output | 2 | Current privilege level |
| paging_o | output | 1 | Paging on |
| prot_o | output | 1 | Protection on |
| op_def_o | output | 2 | Default operand size code |
| op_alt_o | output | 2 | Alternate operand size code |
| addr_def_o | output | 2 | Default address size code |
| addr_alt_o | output | 2 | Alternate address size code |
| stack_o | output | 2 | Stack size code |
| upd_valid_o | output | 1 | One-cycle pulse per reload |

## Verification
The assertions assume that every input is a defined 0 or 1 at each rising edge and that the inputs change only between edges. They allow any combination of the source bits, including some that real software would never set up, such as the 64-bit flag with long mode inactive. The stimulus drives all inputs on falling edges only and draws each source bit freely. Some cycles hold every source unchanged, so the paths where nothing changes and where only the strobe fires are both exercised.

// File: rtl/mode_pkg.sv
package mode_pkg;

  localparam int DPL_W   = 2;
  localparam int SIZE_W  = 2;
  localparam int SUB_W   = 3;

  typedef enum logic {
    MODE_LEGACY = 1'b0,
    MODE_LONG   = 1'b1
  } exec_mode_e;

  typedef enum logic [SUB_W-1:0] {
    SUB_64     = 3'd0,
    SUB_COMPAT = 3'd1,
    SUB_PROT   = 3'd2,
    SUB_V86    = 3'd3,
    SUB_REAL   = 3'd4
  } exec_sub_e;

  localparam logic [SIZE_W-1:0] SZ_16 = 2'd1;
  localparam logic [SIZE_W-1:0] SZ_32 = 2'd2;
  localparam logic [SIZE_W-1:0] SZ_64 = 2'd3;

  typedef struct packed {
    logic             lma;
    logic             pe;
    logic             pg;
    logic             cs_long;
    logic             cs_big;
    logic [DPL_W-1:0] dpl;
    logic             ss_big;
    logic             vm;
  } src_t;

  typedef struct packed {
    exec_mode_e        mode;
    exec_sub_e         sub;
    logic [DPL_W-1:0]  cpl;
    logic              paging;
    logic              prot;
    logic [SIZE_W-1:0] op_def;
    logic [SIZE_W-1:0] op_alt;
    logic [SIZE_W-1:0] addr_def;
    logic [SIZE_W-1:0] addr_alt;
    logic [SIZE_W-1:0] stack;
  } summary_t;

  localparam int SRC_W = $bits(src_t);
  localparam int SUM_W = $bits(summary_t);

endpackage

// File: rtl/mode_rst_sync.sv
module mode_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mode_classifier.sv
module mode_classifier
  import mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  src_t       src,
  output exec_mode_e mode,
  output exec_sub_e  sub
);
  always_comb begin
    if (src.lma) begin
      mode = MODE_LONG;
      sub  = src.cs_long ? SUB_64 : SUB_COMPAT;
    end else begin
      mode = MODE_LEGACY;
      if (!src.pe)     sub = SUB_REAL;
      else if (src.vm) sub = SUB_V86;
      else             sub = SUB_PROT;
    end
  end

  AST_LONG_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_LONG) |-> (sub == SUB_64 || sub == SUB_COMPAT)); // R1
  AST_LEGACY_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_LEGACY) |-> (sub == SUB_REAL || sub == SUB_V86 || sub == SUB_PROT)); // R2
endmodule

// File: rtl/mode_size_resolver.sv
module mode_size_resolver
  import mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  exec_sub_e         sub,
  input  logic              cs_big,
  input  logic              ss_big,
  output logic [SIZE_W-1:0] op_def,
  output logic [SIZE_W-1:0] op_alt,
  output logic [SIZE_W-1:0] addr_def,
  output logic [SIZE_W-1:0] addr_alt,
  output logic [SIZE_W-1:0] stack
);
  logic is64;
  assign is64 = (sub == SUB_64);

  always_comb begin
    if (is64 || cs_big) begin
      op_def = SZ_32;
      op_alt = SZ_16;
    end else begin
      op_def = SZ_16;
      op_alt = SZ_32;
    end
  end

  always_comb begin
    if (is64) begin
      addr_def = SZ_64;
      addr_alt = SZ_32;
    end else if (cs_big) begin
      addr_def = SZ_32;
      addr_alt = SZ_16;
    end else begin
      addr_def = SZ_16;
      addr_alt = SZ_32;
    end
  end

  always_comb begin
    if (is64)        stack = SZ_64;
    else if (ss_big) stack = SZ_32;
    else             stack = SZ_16;
  end

  AST_OP_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_def != op_alt) && (op_def != SZ_64) && (op_alt != SZ_64)); // R4
  AST_ADDR_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_def != addr_alt) && (addr_def != 2'd0) && (addr_alt != 2'd0)); // R5
  AST_STACK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (stack != 2'd0) && ((stack == SZ_64) == (addr_def == SZ_64))); // R6
endmodule

// File: rtl/mode_summary_reg.sv
module mode_summary_reg
  import mode_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_t     src,
  input  logic     kick,
  input  summary_t sum_next,
  output summary_t sum_q,
  output logic     valid_q
);
  src_t     snap_q, snap_d;
  summary_t sum_d;
  logic     valid_d;
  logic     changed, load;

  localparam summary_t SUM_RST = '{
    mode: MODE_LEGACY, sub: SUB_REAL, cpl: '0, paging: 1'b0, prot: 1'b0,
    op_def: SZ_16, op_alt: SZ_32, addr_def: SZ_16, addr_alt: SZ_32, stack: SZ_16};

  assign changed = (src != snap_q);
  assign load    = changed | kick;

  always_comb begin
    snap_d  = snap_q;
    sum_d   = sum_q;
    valid_d = load;
    if (load) begin
      snap_d = src;
      sum_d  = sum_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q  <= '0;
      sum_q   <= SUM_RST;
      valid_q <= 1'b0;
    end else begin
      snap_q  <= snap_d;
      sum_q   <= sum_d;
      valid_q <= valid_d;
    end
  end

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> $stable(sum_q)); // R7
  AST_CHANGE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (src != snap_q) |=> valid_q); // R7
  AST_KICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> valid_q); // R8
endmodule

// File: rtl/mode_summary_unit.sv
module mode_summary_unit
  import mode_pkg::*;
#(
  parameter int KICK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lma_i,
  input  logic              pe_i,
  input  logic              pg_i,
  input  logic              cs_long_i,
  input  logic              cs_big_i,
  input  logic [DPL_W-1:0]  cs_dpl_i,
  input  logic              ss_big_i,
  input  logic              vm_i,
  input  logic              kick_i,
  input  logic [KICK_W-1:0] kick_data_i,
  output logic              mode_o,
  output logic [SUB_W-1:0]  submode_o,
  output logic [DPL_W-1:0]  cpl_o,
  output logic              paging_o,
  output logic              prot_o,
  output logic [SIZE_W-1:0] op_def_o,
  output logic [SIZE_W-1:0] op_alt_o,
  output logic [SIZE_W-1:0] addr_def_o,
  output logic [SIZE_W-1:0] addr_alt_o,
  output logic [SIZE_W-1:0] stack_o,
  output logic              upd_valid_o
);
  logic       rst_sync_n;
  src_t       src;
  exec_mode_e mode_c;
  exec_sub_e  sub_c;
  summary_t   sum_next, sum_q;
  logic       kick_unused;

  assign kick_unused = ^kick_data_i;

  assign src = '{lma: lma_i, pe: pe_i, pg: pg_i, cs_long: cs_long_i,
                 cs_big: cs_big_i, dpl: cs_dpl_i, ss_big: ss_big_i, vm: vm_i};

  mode_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  mode_classifier u_cls (
    .clk(clk), .rst_n(rst_sync_n), .src(src), .mode(mode_c), .sub(sub_c));

  mode_size_resolver u_size (
    .clk(clk), .rst_n(rst_sync_n), .sub(sub_c),
    .cs_big(src.cs_big), .ss_big(src.ss_big),
    .op_def(sum_next.op_def), .op_alt(sum_next.op_alt),
    .addr_def(sum_next.addr_def), .addr_alt(sum_next.addr_alt),
    .stack(sum_next.stack));

  assign sum_next.mode   = mode_c;
  assign sum_next.sub    = sub_c;
  assign sum_next.cpl    = src.dpl;
  assign sum_next.paging = src.pg;
  assign sum_next.prot   = src.pe;

  mode_summary_reg u_reg (
    .clk(clk), .rst_n(rst_sync_n), .src(src), .kick(kick_i),
    .sum_next(sum_next), .sum_q(sum_q), .valid_q(upd_valid_o));

  assign mode_o     = sum_q.mode;
  assign submode_o  = sum_q.sub;
  assign cpl_o      = sum_q.cpl;
  assign paging_o   = sum_q.paging;
  assign prot_o     = sum_q.prot;
  assign op_def_o   = sum_q.op_def;
  assign op_alt_o   = sum_q.op_alt;
  assign addr_def_o = sum_q.addr_def;
  assign addr_alt_o = sum_q.addr_alt;
  assign stack_o    = sum_q.stack;

  AST_CPL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    upd_valid_o |-> (cpl_o == $past(cs_dpl_i) && paging_o == $past(pg_i)
                     && prot_o == $past(pe_i))); // R3
  AST_LONG_MODE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    upd_valid_o |-> (mode_o == $past(lma_i))); // R1
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync_n |-> !upd_valid_o); // R9
endmodule

// File: tb/mode_summary_unit_tb.sv
module mode_summary_unit_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic lma, pe, pg, csl, csb, ssb, vm, kick;
  logic [1:0] dpl;
  logic [31:0] kdata;
  logic mode_o, paging_o, prot_o, valid_o;
  logic [2:0] sub_o;
  logic [1:0] cpl_o, opd, opa, add, ada, stk;

  int vec = 0;
  int bad = 0;
  logic [8:0] prev_src;

  always #4 clk = ~clk;

  mode_summary_unit u_dut (
    .clk(clk), .rst_n(rst_n), .lma_i(lma), .pe_i(pe), .pg_i(pg),
    .cs_long_i(csl), .cs_big_i(csb), .cs_dpl_i(dpl), .ss_big_i(ssb),
    .vm_i(vm), .kick_i(kick), .kick_data_i(kdata),
    .mode_o(mode_o), .submode_o(sub_o), .cpl_o(cpl_o), .paging_o(paging_o),
    .prot_o(prot_o), .op_def_o(opd), .op_alt_o(opa), .addr_def_o(add),
    .addr_alt_o(ada), .stack_o(stk), .upd_valid_o(valid_o));

  function automatic logic [2:0] exp_sub(input logic l, p, c, v);
    if (l) return c ? 3'd0 : 3'd1;
    if (!p) return 3'd4;
    return v ? 3'd3 : 3'd2;
  endfunction

  function automatic logic [8:0] cur_src();
    return {lma, pe, pg, csl, csb, dpl, ssb, vm};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input logic exp_valid);
    logic [2:0] s;
    logic b64;
    s = exp_sub(lma, pe, csl, vm);
    b64 = (s == 3'd0);
    chk(lma ? "R1 mode" : "R2 mode", {31'd0, mode_o}, {31'd0, lma});
    chk(lma ? "R1 submode" : "R2 submode", {29'd0, sub_o}, {29'd0, s});
    chk("R3 cpl/paging/prot", {28'd0, cpl_o, paging_o, prot_o}, {28'd0, dpl, pg, pe});
    chk("R4 operand", {28'd0, opd, opa},
        (b64 || csb) ? 32'h9 : 32'h6);
    chk("R5 address", {28'd0, add, ada},
        b64 ? 32'hE : (csb ? 32'h9 : 32'h6));
    chk("R6 stack", {30'd0, stk}, b64 ? 32'd3 : (ssb ? 32'd2 : 32'd1));
    chk("R7 valid", {31'd0, valid_o}, {31'd0, exp_valid});
  endtask

  task automatic apply(input logic [8:0] s, input logic k, input logic [31:0] kd);
    logic ev;
    {lma, pe, pg, csl, csb, dpl, ssb, vm} = s;
    kick = k; kdata = kd;
    ev = (s != prev_src) || k;
    prev_src = s;
    @(negedge clk);
    check_all(ev);
  endtask

  initial begin
    #1600000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0;
    {lma, pe, pg, csl, csb, dpl, ssb, vm} = '0;
    kick = 1'b0; kdata = '0; prev_src = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 reset", {31'd0, mode_o}, 32'd0);
    chk("R9 reset", {29'd0, sub_o}, 32'd4);
    chk("R9 reset", {26'd0, opd, opa, add, ada, stk}, {26'd0, 2'd1, 2'd2, 2'd1, 2'd2, 2'd1});
    chk("R9 reset", {28'd0, cpl_o, paging_o, prot_o, valid_o}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all(1'b0);
    // directed corners: R1 64-bit, compat; R2 real, v86, prot
    apply(9'b1_1_1_1_0_00_0_0, 1'b0, 32'd0);
    apply(9'b1_1_1_1_1_11_1_0, 1'b0, 32'd0);
    apply(9'b1_1_1_0_1_10_1_0, 1'b0, 32'd0);
    apply(9'b1_1_1_0_0_01_0_1, 1'b0, 32'd0);
    apply(9'b0_0_0_1_1_00_1_1, 1'b0, 32'd0);
    apply(9'b0_1_0_0_0_11_0_1, 1'b0, 32'd0);
    apply(9'b0_1_1_0_1_10_1_0, 1'b0, 32'd0);
    apply(9'b0_1_1_1_0_01_0_0, 1'b0, 32'd0);
    // R7 hold with no strobe: outputs unchanged, no valid
    apply(9'b0_1_1_1_0_01_0_0, 1'b0, 32'd0);
    apply(9'b0_1_1_1_0_01_0_0, 1'b0, 32'd0);
    // R8 strobe with garbage data: valid pulse, outputs unchanged
    apply(9'b0_1_1_1_0_01_0_0, 1'b1, 32'hFFFF_FFFF);
    apply(9'b0_1_1_1_0_01_0_0, 1'b1, 32'h1234_5678);
    apply(9'b0_1_1_1_0_01_0_0, 1'b0, 32'hDEAD_BEEF);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [8:0] s;
      s = ($urandom_range(0, 3) == 0) ? prev_src : 9'($urandom);
      apply(s, ($urandom_range(0, 4) == 0), $urandom);
    end
    kick = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule